// File: doc/BRIEF.md
# Page-Organised Flash Emulation Shim

This block makes a bit-alterable non-volatile array look like a page-organised embedded flash, so that host logic written for flash can drive it unchanged. The host issues three commands through one port: erase a whole page, program one word, or toggle selected bits of one word. Writes follow flash polarity. Erase drives every bit of a page to one. Program can only clear bits. It does this in one pass that touches only the bits that differ from the supplied data.

To change bits in both directions at an address that already holds data, the toggle command runs two masked phases. The first phase clears the chosen bits that must become zero. The second phase sets the chosen bits that must become one. While an operation runs, the shim reports busy and turns new commands away. A read port returns stored words one cycle after the request whenever the shim is idle.

The array model sits inside the datapath. A controller sequences the work one word per cycle. A small mask generator decides which bits each phase may change.

Top module: `flash_page_shim`

## Requirements
- R1: After reset, busy, done and progErr are 0, and every word reads 0xFFFFFFFF.
- R2: An erase (cmdOp 2'b00) sets all PAGE_WORDS words of the page selected by cmdAddr[ADDR_W-1:PAGE_BITS] to all ones. The word bits of cmdAddr are ignored, and words in other pages keep their contents.
- R3: After the clock edge that accepts an erase, busy is high for exactly PAGE_WORDS cycles. done is a single-cycle pulse in the first cycle in which busy is low again.
- R4: A program (cmdOp 2'b01) stores the old word AND cmdData at cmdAddr. busy is high for exactly one cycle.
- R5: If cmdData has a 1 where the stored bit is 0, that bit stays 0 and progErr is 1 from the done cycle until the next accepted command. A program that only clears bits leaves progErr at 0.
- R6: A toggle (cmdOp 2'b10) stores (old AND NOT cmdMask) OR (cmdData AND cmdMask). This takes a clear phase followed by a set phase, so busy is high for exactly two cycles.
- R7: A command presented while busy is high gets cmdReject=1 and cmdAccept=0, and it changes no stored word.
- R8: rdEn with busy low gives rdValid=1 and the word at rdAddr on rdData in the next cycle. rdEn with busy high gives rdValid=0 in the next cycle.
- R9: cmdOp 2'b11 is reserved. It is rejected (cmdReject=1) even when the shim is idle, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | 00 erase page, 01 program word, 10 toggle word, 11 reserved |
| cmdAddr | input | ADDR_W | Word address; upper bits select the page |
| cmdData | input | DATA_W | Program or toggle data |
| cmdMask | input | DATA_W | Toggle bit select (1 = bit may change) |
| cmdAccept | output | 1 | Command taken this cycle |
| cmdReject | output | 1 | Command refused this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| progErr | output | 1 | Last program tried to set a bit |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W | Read word address |
| rdData | output | DATA_W | Read data |
| rdValid | output | 1 | rdData valid |

## Verification
The assertions take for granted that cmdValid and rdEn stay low while reset is active. Under that assumption, the first cycle after reset starts with no pending read and no running operation. The bench drives all inputs at the falling edge and holds a command for one cycle only. It raises requests during busy only on purpose, to exercise rejection and the blocked read. Because of this, every busy run the checker measures comes from one accepted command.

// File: rtl/flash_shim_pkg.sv
package flash_shim_pkg;

  typedef enum logic [1:0] {
    OP_ERASE  = 2'b00,
    OP_PROG   = 2'b01,
    OP_TOGGLE = 2'b10,
    OP_RSVD   = 2'b11
  } shim_op_e;

  typedef enum logic [1:0] {
    PH_ERASE = 2'b00,
    PH_PROG  = 2'b01,
    PH_CLR   = 2'b10,
    PH_SET   = 2'b11
  } wr_phase_e;

  typedef struct packed {
    logic      capture;
    logic      wrEn;
    wr_phase_e phase;
  } shim_strobe_t;

endpackage

// File: rtl/flash_shim_mask.sv
module flash_shim_mask
  import flash_shim_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  wr_phase_e         phase,
  input  logic [DATA_W-1:0] stored,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] nextWord,
  output logic              setAttempt
);

  logic [DATA_W-1:0] clrBits;
  logic [DATA_W-1:0] setBits;

  always_comb begin
    clrBits    = '0;
    setBits    = '0;
    setAttempt = |(data & ~stored);
    unique case (phase)
      PH_ERASE: setBits = '1;
      PH_PROG:  clrBits = stored & ~data;
      PH_CLR:   clrBits = stored & mask & ~data;
      PH_SET:   setBits = ~stored & mask & data;
      default:  clrBits = '0;
    endcase
    nextWord = (stored & ~clrBits) | setBits;
  end

endmodule

// File: rtl/flash_shim_ctrl.sv
module flash_shim_ctrl
  import flash_shim_pkg::*;
#(
  parameter int PAGE_WORDS = 16,
  localparam int PAGE_BITS = $clog2(PAGE_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  output logic                 cmdAccept,
  output logic                 cmdReject,
  output logic                 busy,
  output logic                 done,
  output shim_strobe_t         strobe,
  output logic [PAGE_BITS-1:0] wordIdx
);

  localparam logic [PAGE_BITS-1:0] LAST_IDX = PAGE_BITS'(PAGE_WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ERASE, S_PROG, S_CLR, S_SET} state_e;

  state_e   state;
  shim_op_e op;
  logic     opLegal;

  always_comb begin
    op        = shim_op_e'(cmdOp);
    opLegal   = (op != OP_RSVD);
    busy      = (state != S_IDLE);
    cmdAccept = cmdValid && !busy && opLegal;
    cmdReject = cmdValid && !cmdAccept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wordIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmdAccept) begin
            wordIdx <= '0;
            unique case (op)
              OP_ERASE:  state <= S_ERASE;
              OP_PROG:   state <= S_PROG;
              OP_TOGGLE: state <= S_CLR;
              default:   state <= S_IDLE;
            endcase
          end
        end
        S_ERASE: begin
          wordIdx <= wordIdx + 1'b1;
          if (wordIdx == LAST_IDX) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        S_PROG: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        S_CLR: state <= S_SET;
        S_SET: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture = cmdAccept;
    strobe.wrEn    = busy;
    unique case (state)
      S_PROG:  strobe.phase = PH_PROG;
      S_CLR:   strobe.phase = PH_CLR;
      S_SET:   strobe.phase = PH_SET;
      default: strobe.phase = PH_ERASE;
    endcase
  end

endmodule

// File: rtl/flash_shim_dp.sv
module flash_shim_dp
  import flash_shim_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PAGE_WORDS = 16,
  parameter int NUM_PAGES  = 8,
  localparam int PAGE_BITS = $clog2(PAGE_WORDS),
  localparam int DEPTH     = PAGE_WORDS * NUM_PAGES,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  shim_strobe_t         strobe,
  input  logic [PAGE_BITS-1:0] wordIdx,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [DATA_W-1:0]    cmdData,
  input  logic [DATA_W-1:0]    cmdMask,
  input  logic                 rdReq,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid,
  output logic                 progErr
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] maskQ;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] storedWord;
  logic [DATA_W-1:0] nextWord;
  logic              setAttempt;

  always_comb begin
    if (strobe.phase == PH_ERASE) wrAddr = {addrQ[ADDR_W-1:PAGE_BITS], wordIdx};
    else                          wrAddr = addrQ;
    storedWord = mem[wrAddr];
  end

  flash_shim_mask #(.DATA_W(DATA_W)) u_mask (
    .phase     (strobe.phase),
    .stored    (storedWord),
    .data      (dataQ),
    .mask      (maskQ),
    .nextWord  (nextWord),
    .setAttempt(setAttempt)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      maskQ   <= '0;
      progErr <= 1'b0;
    end else if (strobe.capture) begin
      addrQ   <= cmdAddr;
      dataQ   <= cmdData;
      maskQ   <= cmdMask;
      progErr <= 1'b0;
    end else if (strobe.wrEn && strobe.phase == PH_PROG) begin
      progErr <= setAttempt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strobe.wrEn) begin
      mem[wrAddr] <= nextWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdReq;
      if (rdReq) rdData <= mem[rdAddr];
    end
  end

endmodule

// File: rtl/flash_page_shim.sv
module flash_page_shim
  import flash_shim_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PAGE_WORDS = 16,
  parameter int NUM_PAGES  = 8,
  localparam int PAGE_BITS = $clog2(PAGE_WORDS),
  localparam int ADDR_W    = $clog2(PAGE_WORDS * NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [DATA_W-1:0] cmdMask,
  output logic              cmdAccept,
  output logic              cmdReject,
  output logic              busy,
  output logic              done,
  output logic              progErr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  shim_strobe_t         strobe;
  logic [PAGE_BITS-1:0] wordIdx;
  logic                 rdReq;

  assign rdReq = rdEn && !busy;

  flash_shim_ctrl #(.PAGE_WORDS(PAGE_WORDS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdAccept(cmdAccept),
    .cmdReject(cmdReject),
    .busy     (busy),
    .done     (done),
    .strobe   (strobe),
    .wordIdx  (wordIdx)
  );

  flash_shim_dp #(
    .DATA_W    (DATA_W),
    .PAGE_WORDS(PAGE_WORDS),
    .NUM_PAGES (NUM_PAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wordIdx(wordIdx),
    .cmdAddr(cmdAddr),
    .cmdData(cmdData),
    .cmdMask(cmdMask),
    .rdReq  (rdReq),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .rdValid(rdValid),
    .progErr(progErr)
  );

endmodule

// File: rtl/flash_shim_chk.sv
module flash_shim_chk #(
  parameter int PAGE_WORDS = 16
) (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic cmdAccept,
  input logic cmdReject,
  input logic busy,
  input logic done,
  input logic progErr,
  input logic rdEn,
  input logic rdValid
);

  localparam int RUN_W = $clog2(PAGE_WORDS) + 2;
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  // R3
  erase_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(PAGE_WORDS));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R7
  reject_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && busy) |-> (cmdReject && !cmdAccept));

  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdAccept |=> busy);

  // R5
  err_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progErr) |-> done);

  // R8
  read_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn && !busy));

  // R8
  read_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && busy) |=> !rdValid);

endmodule

bind flash_page_shim flash_shim_chk #(.PAGE_WORDS(PAGE_WORDS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdAccept(cmdAccept),
  .cmdReject(cmdReject),
  .busy     (busy),
  .done     (done),
  .progErr  (progErr),
  .rdEn     (rdEn),
  .rdValid  (rdValid)
);

// File: tb/flash_page_shim_tb.sv
module flash_page_shim_tb;

  localparam int DATA_W = 32;
  localparam int PW     = 16;
  localparam int NP     = 8;
  localparam int DEPTH  = PW * NP;
  localparam int AW     = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rstN;
  logic              cmdValid;
  logic [1:0]        cmdOp;
  logic [AW-1:0]     cmdAddr;
  logic [DATA_W-1:0] cmdData;
  logic [DATA_W-1:0] cmdMask;
  logic              cmdAccept, cmdReject, busy, done, progErr;
  logic              rdEn;
  logic [AW-1:0]     rdAddr;
  logic [DATA_W-1:0] rdData;
  logic              rdValid;

  int total = 0;
  int bad   = 0;

  logic [DATA_W-1:0] model [DEPTH];
  logic [DATA_W-1:0] expQ [$];
  string             tagQ [$];

  always #5 clk = ~clk;

  flash_page_shim #(.DATA_W(DATA_W), .PAGE_WORDS(PW), .NUM_PAGES(NP)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdMask(cmdMask),
    .cmdAccept(cmdAccept), .cmdReject(cmdReject), .busy(busy), .done(done),
    .progErr(progErr), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .rdValid(rdValid)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results as rdValid appears
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected rdValid", 1, 0);
      end else begin
        logic [DATA_W-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData === e, t, rdData, e);
      end
    end
  end

  task automatic readWord(input int a, input string tag);
    @(negedge clk);
    rdEn   = 1'b1;
    rdAddr = AW'(a);
    expQ.push_back(model[a]);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic runCmd(input logic [1:0] op, input int a,
                        input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] m,
                        input int expCycles, input bit expErr, input string tag);
    int n;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = AW'(a); cmdData = d; cmdMask = m;
    #1;
    check(cmdAccept === 1'b1 && cmdReject === 1'b0, {tag, " accept"}, cmdAccept, 1);
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    check(n == expCycles, {tag, " busy length"}, n, expCycles);
    check(done === 1'b1, {tag, " done pulse"}, done, 1);
    if (op == 2'b01)
      check(progErr === expErr, {tag, " progErr"}, progErr, expErr);
    @(negedge clk);
    check(done === 1'b0, {tag, " done single cycle"}, done, 0);
    unique case (op)
      2'b00: for (int i = 0; i < PW; i++) model[(a / PW) * PW + i] = '1;
      2'b01: model[a] = model[a] & d;
      2'b10: model[a] = (model[a] & ~m) | (d & m);
      default: ;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = 2'b00; cmdAddr = '0;
    cmdData = '0; cmdMask = '0; rdEn = 1'b0; rdAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy === 1'b0 && done === 1'b0 && progErr === 1'b0, "R1 status after reset",
          {busy, done, progErr}, 0);
    readWord(0, "R1 word 0 erased");
    readWord(77, "R1 word 77 erased");
    readWord(DEPTH - 1, "R1 last word erased");

    // R4 program clears only
    runCmd(2'b01, 5, 32'hA5A5_0F0F, '0, 1, 1'b0, "R4 program");
    readWord(5, "R4 program result");
    // R5 attempt to set a cleared bit
    runCmd(2'b01, 5, 32'hFFFF_00FF, '0, 1, 1'b1, "R5 set attempt");
    readWord(5, "R5 cleared bits stay 0");
    // progErr holds until next accept
    check(progErr === 1'b1, "R5 progErr holds", progErr, 1);
    runCmd(2'b01, 6, 32'h0000_0000, '0, 1, 1'b0, "R5 clear-only program");

    // R6 toggle both directions
    runCmd(2'b10, 5, 32'h1234_5678, 32'hFF00_FF00, 2, 1'b0, "R6 toggle");
    readWord(5, "R6 toggle result");
    readWord(6, "R6 neighbour word intact");

    // R2 setup: fill page 1 and page 2 words
    runCmd(2'b01, 16, 32'h0, '0, 1, 1'b0, "R2 setup p1w0");
    runCmd(2'b01, 31, 32'h1111_0000, '0, 1, 1'b0, "R2 setup p1w15");
    runCmd(2'b01, 32, 32'h00FF_00FF, '0, 1, 1'b0, "R2 setup p2w0");
    runCmd(2'b01, 40, 32'h00FF_00FF, '0, 1, 1'b0, "R7 setup");
    // R2, R3: erase page 1 using a nonzero word index
    runCmd(2'b00, 23, '0, '0, PW, 1'b0, "R3 erase page 1");
    for (int i = 16; i < 32; i++) readWord(i, "R2 page 1 erased");
    readWord(15, "R2 page 0 untouched");
    readWord(32, "R2 page 2 untouched");
    readWord(5, "R2 earlier word untouched");

    // R7 reject while busy, R8 read while busy
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'b00; cmdAddr = AW'(48);
    @(posedge clk);
    @(negedge clk);
    cmdOp = 2'b01; cmdAddr = AW'(40); cmdData = 32'h0; rdEn = 1'b1; rdAddr = AW'(40);
    #1;
    check(cmdReject === 1'b1 && cmdAccept === 1'b0, "R7 reject during busy",
          {cmdReject, cmdAccept}, 2'b10);
    @(negedge clk);
    cmdValid = 1'b0; rdEn = 1'b0;
    check(rdValid === 1'b0, "R8 read blocked while busy", rdValid, 0);
    while (busy) @(negedge clk);
    for (int i = 48; i < 64; i++) model[i] = '1;
    readWord(40, "R7 rejected program had no effect");
    readWord(48, "R7 erase still completed");

    // R9 reserved op
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'b11; cmdAddr = AW'(32);
    #1;
    check(cmdReject === 1'b1 && cmdAccept === 1'b0, "R9 reserved op rejected",
          {cmdReject, cmdAccept}, 2'b10);
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy === 1'b0, "R9 busy stays low", busy, 0);
    readWord(32, "R9 no store change");

    // R2 boundary: last page
    runCmd(2'b01, DEPTH - 1, 32'h0, '0, 1, 1'b0, "R2 setup last");
    runCmd(2'b01, DEPTH - PW, 32'h0F0F_0F0F, '0, 1, 1'b0, "R2 setup last page first");
    runCmd(2'b00, DEPTH - 1, '0, '0, PW, 1'b0, "R3 erase last page");
    readWord(DEPTH - 1, "R2 last word erased");
    readWord(DEPTH - PW, "R2 last page first erased");
    readWord(DEPTH - PW - 1, "R2 previous page untouched");

    // R8 back-to-back reads
    @(negedge clk);
    rdEn = 1'b1; rdAddr = AW'(5);
    expQ.push_back(model[5]); tagQ.push_back("R8 back-to-back first");
    @(negedge clk);
    rdAddr = AW'(32);
    expQ.push_back(model[32]); tagQ.push_back("R8 back-to-back second");
    @(negedge clk);
    rdEn = 1'b0;
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8 all reads returned", expQ.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule